// File: doc/BRIEF.md
# Shared-Cache Barrier Filter

This block sits next to the controller of a shared cache level and synchronizes a fixed group of hardware threads without any dedicated signalling wires or special instructions. It watches the snooped stream of invalidations and fill requests. A thread reports that it has reached the barrier by invalidating a chosen arrival line. It then tries to refill that line. The filter withholds that fill until every enabled thread has reported. When the last one arrives, all waiting threads are freed together and their withheld fills are granted back one at a time.

Each thread moves through three states: Executing, Blocking and Resuming. A Resuming thread returns to Executing only when it invalidates a separate exit line. A fill that is delivered again must not end the Resuming state on its own. In alternating mode the filter switches between two arrival lines after each barrier. Arriving at the current line also counts as leaving the previous barrier, so no exit invalidation is needed. One instance serves one barrier. A controller may hold several instances.

Top module: `barrier_filter`

## Requirements
- R1: After reset, every thread is Executing, all three address registers are 0, the thread mask is 0 and alternating mode is off. A fill to a watched arrival address is answered one cycle later with `rsp_valid_o`=1 and `rsp_hold_o`=0, and `gnt_valid_o` stays 0.
- R2: A snooped operation with `snp_op_i`=1 (invalidate) to the current arrival address from an enabled, Executing thread puts that thread in Blocking. A later fill (`snp_op_i`=2) from that thread to the same address is answered with `rsp_valid_o`=1 and `rsp_hold_o`=1, and the fill is kept pending.
- R3: A fill to a watched arrival address from a thread that is not Blocking, including a thread outside the mask, is answered the next cycle with `rsp_hold_o`=0. A fill to any other address produces no response (`rsp_valid_o`=0).
- R4: A repeated invalidation from a thread that is already Blocking is not counted again. The barrier releases only after each enabled thread has arrived once.
- R5: When the last enabled thread arrives, the arrival count returns to zero and every Blocking thread, including the arriving one, becomes Resuming in the same cycle. Their fills to the arrival address are then served at once.
- R6: Pending fills are granted starting in the second cycle after the release edge. Grants are one-cycle pulses on `gnt_valid_o` with the thread id on `gnt_tid_o`, one per cycle, in ascending thread-id order. Each pending fill is granted exactly once.
- R7: Outside alternating mode, a Resuming thread ignores further invalidations of the arrival address, and its fills are served. It becomes Executing only when it invalidates the exit address, and after that it can arrive at the next barrier.
- R8: In alternating mode the arrival address starts as arrival register 0 and switches to the other register at each release. An invalidation of the current address from a Resuming thread counts as both exit and arrival. An invalidation of the other address is ignored. Fills to the other address are answered and never held.
- R9: Configuration writes use `cfg_sel_i`: 0 = arrival address 0, 1 = arrival address 1, 2 = exit address, 3 = control. In the control word, bits [NTHR-1:0] are the thread mask and bit NTHR enables alternating mode. Every write returns all threads to Executing and clears the count, the pending fills and the alternating phase.
- R10: Invalidations from threads outside the mask have no effect on the arrival count or on any thread state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | ADDR_W | Configuration write data |
| snp_op_i | input | 2 | Snooped operation: 0 idle, 1 invalidate, 2 fill |
| snp_addr_i | input | ADDR_W | Snooped line address |
| snp_tid_i | input | TID_W | Thread issuing the snooped operation |
| rsp_valid_o | output | 1 | A fill to a watched address was seen in the previous cycle |
| rsp_hold_o | output | 1 | That fill is withheld (1) or served now (0) |
| rsp_tid_o | output | TID_W | Thread of that fill |
| gnt_valid_o | output | 1 | One-cycle grant of a withheld fill |
| gnt_tid_o | output | TID_W | Thread whose withheld fill is granted |

## Verification
If a thread is stuck in the wrong state, it shows up on the very next fill from that thread. The response flag comes back one cycle later with the hold bit flipped. An arrival count that is off by one releases the barrier too early or never. This is seen within a cycle as a fill that should be held coming back as served, or as a grant burst that fails to start in the second cycle after the last arrival. Lost or duplicated pending fills appear directly in the ordered grant sequence. The bench therefore checks every grant cycle position for each mask of a four-thread configuration.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int MAX_THR = 16;

    // Per-thread barrier progress
    typedef enum logic [1:0] {
        TS_EXEC   = 2'd0,
        TS_BLOCK  = 2'd1,
        TS_RESUME = 2'd2
    } thr_state_e;

    // Snooped operation code
    typedef enum logic [1:0] {
        SNP_IDLE = 2'd0,
        SNP_INV  = 2'd1,
        SNP_FILL = 2'd2
    } snp_op_e;

    // Configuration register select
    typedef enum logic [1:0] {
        CFG_ARRIVE0 = 2'd0,
        CFG_ARRIVE1 = 2'd1,
        CFG_EXIT    = 2'd2,
        CFG_CTRL    = 2'd3
    } cfg_sel_e;

    // Number of set bits in a padded thread vector
    function automatic logic [4:0] popcnt16(input logic [MAX_THR-1:0] v);
        logic [4:0] c;
        c = '0;
        for (int i = 0; i < MAX_THR; i++) c = c + 5'(v[i]);
        return c;
    endfunction

    // Index of the lowest set bit; 16 when none is set
    function automatic logic [4:0] first_set16(input logic [MAX_THR-1:0] v);
        logic [4:0] r;
        r = 5'd16;
        for (int i = MAX_THR - 1; i >= 0; i--) if (v[i]) r = 5'(i);
        return r;
    endfunction

endpackage

// File: rtl/bf_cfg_regs.sv
module bf_cfg_regs
    import bf_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] arr0_o,
    output logic [ADDR_W-1:0] arr1_o,
    output logic [ADDR_W-1:0] exit_o,
    output logic [NTHR-1:0]   mask_o,
    output logic              pp_o,
    output logic              clear_o
);

    cfg_sel_e sel;
    assign sel     = cfg_sel_e'(sel_i);
    // Any write restarts the barrier from a clean state
    assign clear_o = wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr0_o <= '0;
            arr1_o <= '0;
            exit_o <= '0;
            mask_o <= '0;
            pp_o   <= 1'b0;
        end else if (wr_i) begin
            case (sel)
                CFG_ARRIVE0: arr0_o <= wdata_i;
                CFG_ARRIVE1: arr1_o <= wdata_i;
                CFG_EXIT:    exit_o <= wdata_i;
                CFG_CTRL: begin
                    mask_o <= wdata_i[NTHR-1:0];
                    pp_o   <= wdata_i[NTHR];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bf_thread_fsm.sv
module bf_thread_fsm
    import bf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       en_i,
    input  logic       pp_i,
    input  logic       arr_hit_i,
    input  logic       exit_hit_i,
    input  logic       release_i,
    output thr_state_e state_o,
    output logic       acc_o
);

    thr_state_e st_q, st_d;

    always_comb begin
        // Arrival counts from Executing, or from Resuming when the
        // new arrival also stands for the exit of the previous barrier
        acc_o = en_i && arr_hit_i &&
                (st_q == TS_EXEC || (pp_i && st_q == TS_RESUME));
        st_d  = st_q;
        if (release_i && (st_q == TS_BLOCK || acc_o))
            st_d = TS_RESUME;
        else if (acc_o)
            st_d = TS_BLOCK;
        else if (exit_hit_i && st_q == TS_RESUME)
            st_d = TS_EXEC;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) st_q <= TS_EXEC;
        else                st_q <= st_d;
    end

    assign state_o = st_q;

    AST_RESUME_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_RESUME && $past(st_q) != TS_RESUME) |-> $past(release_i)); // R5

    AST_BLOCK_HELD_TO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == TS_BLOCK && st_q != TS_BLOCK) |-> ($past(release_i) || $past(clear_i))); // R4

endmodule

// File: rtl/bf_grant_arb.sv
module bf_grant_arb
    import bf_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [NTHR-1:0]  set_i,
    input  logic [NTHR-1:0]  elig_i,
    output logic             gnt_valid_o,
    output logic [TID_W-1:0] gnt_tid_o
);

    logic [NTHR-1:0] pend_q;
    logic [NTHR-1:0] cand;
    logic [NTHR-1:0] gnt_oh;
    logic [4:0]      pick;
    logic            found;

    // Only fills whose thread has left Blocking may be answered
    assign cand  = pend_q & elig_i;
    assign pick  = first_set16(MAX_THR'(cand));
    assign found = !pick[4];
    assign gnt_oh = found ? (NTHR'(1) << pick[3:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pend_q      <= '0;
            gnt_valid_o <= 1'b0;
            gnt_tid_o   <= '0;
        end else begin
            pend_q      <= (pend_q & ~gnt_oh) | set_i;
            gnt_valid_o <= found;
            gnt_tid_o   <= TID_W'(pick[3:0]);
        end
    end

    AST_GNT_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> ((($past(pend_q) >> gnt_tid_o) & NTHR'(1)) != '0)); // R6

    AST_GNT_RETIRED: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> !pend_q[gnt_tid_o]); // R6

endmodule

// File: rtl/barrier_filter.sv
module barrier_filter
    import bf_pkg::*;
#(
    parameter  int NTHR   = 4,
    parameter  int ADDR_W = 32,
    localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int CNT_W  = $clog2(NTHR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [ADDR_W-1:0] cfg_wdata_i,
    input  logic [1:0]        snp_op_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [TID_W-1:0]  snp_tid_i,
    output logic              rsp_valid_o,
    output logic              rsp_hold_o,
    output logic [TID_W-1:0]  rsp_tid_o,
    output logic              gnt_valid_o,
    output logic [TID_W-1:0]  gnt_tid_o
);

    // ---------------- configuration ----------------
    logic [ADDR_W-1:0] arr0, arr1, exit_a;
    logic [NTHR-1:0]   mask;
    logic              pp, clear;

    bf_cfg_regs #(.NTHR(NTHR), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cfg_wr_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .arr0_o  (arr0),
        .arr1_o  (arr1),
        .exit_o  (exit_a),
        .mask_o  (mask),
        .pp_o    (pp),
        .clear_o (clear)
    );

    // ---------------- snoop decode ----------------
    snp_op_e           op;
    logic              is_inv, is_fill;
    logic              phase_q;
    logic [ADDR_W-1:0] cur_arr, oth_arr;
    logic              cur_match, oth_match, exit_match;

    assign op         = snp_op_e'(snp_op_i);
    assign is_inv     = (op == SNP_INV);
    assign is_fill    = (op == SNP_FILL);
    assign cur_arr    = (pp && phase_q) ? arr1 : arr0;
    assign oth_arr    = (pp && phase_q) ? arr0 : arr1;
    assign cur_match  = (snp_addr_i == cur_arr);
    assign oth_match  = pp && (snp_addr_i == oth_arr);
    assign exit_match = (snp_addr_i == exit_a);

    // ---------------- per-thread state ----------------
    logic [NTHR-1:0] tid_hit, acc, blk;
    thr_state_e      st [NTHR];
    logic            release_b;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign tid_hit[t] = (snp_tid_i == TID_W'(t));

        bf_thread_fsm u_thr (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (clear),
            .en_i       (mask[t]),
            .pp_i       (pp),
            .arr_hit_i  (is_inv && cur_match && tid_hit[t]),
            .exit_hit_i (is_inv && exit_match && tid_hit[t]),
            .release_i  (release_b),
            .state_o    (st[t]),
            .acc_o      (acc[t])
        );

        assign blk[t] = (st[t] == TS_BLOCK);
    end

    // ---------------- arrival counter ----------------
    logic [CNT_W-1:0] cnt_q, need;
    logic             acc_any;

    assign need      = CNT_W'(popcnt16(MAX_THR'(mask)));
    assign acc_any   = |acc;
    assign release_b = acc_any && ((cnt_q + CNT_W'(1)) == need);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (release_b) begin
            cnt_q   <= '0;
            phase_q <= pp ? ~phase_q : phase_q;
        end else if (acc_any) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // ---------------- fill response ----------------
    logic            fill_watch, fill_hold;
    logic [NTHR-1:0] hold_vec;

    assign fill_watch = is_fill && (cur_match || oth_match);
    assign fill_hold  = is_fill && cur_match && |(blk & tid_hit);
    assign hold_vec   = fill_hold ? tid_hit : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_hold_o  <= 1'b0;
            rsp_tid_o   <= '0;
        end else begin
            rsp_valid_o <= fill_watch;
            rsp_hold_o  <= fill_hold;
            rsp_tid_o   <= snp_tid_i;
        end
    end

    // ---------------- withheld-fill grants ----------------
    bf_grant_arb #(.NTHR(NTHR), .TID_W(TID_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .set_i       (hold_vec),
        .elig_i      (~blk),
        .gnt_valid_o (gnt_valid_o),
        .gnt_tid_o   (gnt_tid_o)
    );

    AST_CNT_BELOW_NEED: assert property (@(posedge clk) disable iff (rst)
        (need != '0) |-> (cnt_q < need)); // R4

    AST_RELEASE_ZEROES_CNT: assert property (@(posedge clk) disable iff (rst)
        release_b |=> (cnt_q == '0)); // R5

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i |=> (cnt_q == '0 && !gnt_valid_o && !phase_q)); // R9

endmodule

// File: tb/barrier_filter_tb.sv
module barrier_filter_tb;

    localparam int NT = 4;
    localparam int AW = 16;
    localparam logic [AW-1:0] A0 = 16'h0040;
    localparam logic [AW-1:0] A1 = 16'h0080;
    localparam logic [AW-1:0] EX = 16'h00C0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [1:0]    snp_op = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [1:0]    snp_tid = '0;
    logic          rsp_valid, rsp_hold, gnt_valid;
    logic [1:0]    rsp_tid, gnt_tid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    barrier_filter #(.NTHR(NT), .ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_i    (cfg_wr),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .snp_op_i    (snp_op),
        .snp_addr_i  (snp_addr),
        .snp_tid_i   (snp_tid),
        .rsp_valid_o (rsp_valid),
        .rsp_hold_o  (rsp_hold),
        .rsp_tid_o   (rsp_tid),
        .gnt_valid_o (gnt_valid),
        .gnt_tid_o   (gnt_tid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Drives one snoop for one cycle; returns when its response is visible
    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input int tid);
        @(negedge clk);
        snp_op = op; snp_addr = a; snp_tid = tid[1:0];
        @(negedge clk);
        snp_op = 2'd0;
    endtask

    task automatic fill_chk(input logic [AW-1:0] a, input int tid,
                            input bit exp_hold, input string req);
        snoop(2'd2, a, tid);
        chk(rsp_valid == 1'b1, req, "rsp_valid", int'(rsp_valid), 1);
        chk(rsp_hold == exp_hold && rsp_tid == tid[1:0], req, "rsp_hold",
            int'(rsp_hold), int'(exp_hold));
    endtask

    // Expects grants one per cycle, ascending, starting at the next negedge
    task automatic collect(input logic [NT-1:0] exp, input string req);
        logic [NT-1:0] rem;
        rem = exp;
        for (int k = 0; k < NT + 2; k++) begin
            int e;
            @(negedge clk);
            e = -1;
            for (int i = NT - 1; i >= 0; i--) if (rem[i]) e = i;
            if (e >= 0) begin
                chk(gnt_valid && gnt_tid == e[1:0], req, "grant tid",
                    gnt_valid ? int'(gnt_tid) : -1, e);
                rem[e] = 1'b0;
            end else begin
                chk(!gnt_valid, req, "no grant", int'(gnt_valid), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!rsp_valid && !gnt_valid, "R1", "idle outputs", int'(rsp_valid | gnt_valid), 0);
        fill_chk('0, 1, 1'b0, "R1");

        cfg_write(2'd0, A0);
        cfg_write(2'd1, A1);
        cfg_write(2'd2, EX);

        // R3: unrelated address gives no response
        snoop(2'd2, 16'h0123, 0);
        chk(!rsp_valid, "R3", "unwatched fill", int'(rsp_valid), 0);

        for (int m = 1; m < 16; m++) begin
            int ord [NT];
            int n;
            logic [NT-1:0] mk, held;
            mk = m[NT-1:0];
            n = 0;
            for (int i = 0; i < NT; i++) begin
                int t;
                t = (i + m) % NT;
                if (mk[t]) begin ord[n] = t; n++; end
            end

            cfg_write(2'd3, AW'(mk));
            // R9: pending fills of the previous round are dropped
            collect('0, "R9");
            fill_chk(A0, ord[0], 1'b0, "R9");

            // R10: threads outside the mask do not count
            for (int t = 0; t < NT; t++) if (!mk[t]) snoop(2'd1, A0, t);

            held = '0;
            for (int i = 0; i < n - 1; i++) begin
                snoop(2'd1, A0, ord[i]);
                snoop(2'd1, A0, ord[i]);          // R4 duplicate
                fill_chk(A0, ord[i], 1'b1, "R2");
                held[ord[i]] = 1'b1;
            end
            if (n >= 2) fill_chk(A0, ord[0], 1'b1, "R4");
            for (int t = 0; t < NT; t++) if (!mk[t]) fill_chk(A0, t, 1'b0, "R3");

            snoop(2'd1, A0, ord[n-1]);
            collect(held, "R6");
            fill_chk(A0, ord[n-1], 1'b0, "R5");
            fill_chk(A0, ord[0], 1'b0, "R5");

            // R7: Resuming ignores arrival line until exit
            snoop(2'd1, A0, ord[0]);
            fill_chk(A0, ord[0], 1'b0, "R7");
            for (int i = 0; i < n; i++) snoop(2'd1, EX, ord[i]);
            snoop(2'd1, A0, ord[0]);
            fill_chk(A0, ord[0], (n >= 2), "R7");
            if (n == 1) collect('0, "R7");
        end

        // Alternating mode: mask 0xF, bit 4 enables it
        cfg_write(2'd3, 16'h001F);
        collect('0, "R9");
        snoop(2'd1, A1, 0);
        fill_chk(A1, 0, 1'b0, "R8");
        fill_chk(A0, 0, 1'b0, "R8");
        snoop(2'd1, A0, 3); fill_chk(A0, 3, 1'b1, "R8");
        snoop(2'd1, A0, 1); fill_chk(A0, 1, 1'b1, "R8");
        snoop(2'd1, A0, 0); fill_chk(A0, 0, 1'b1, "R8");
        snoop(2'd1, A0, 2);
        collect(4'b1011, "R6");

        snoop(2'd1, A1, 0);
        fill_chk(A1, 0, 1'b1, "R8");
        fill_chk(A0, 1, 1'b0, "R8");
        snoop(2'd1, A0, 1);
        fill_chk(A1, 1, 1'b0, "R8");
        snoop(2'd1, A1, 1);
        snoop(2'd1, A1, 3);
        snoop(2'd1, A1, 2);
        collect(4'b0001, "R6");
        snoop(2'd1, A0, 1);
        fill_chk(A0, 1, 1'b1, "R8");
        fill_chk(A1, 1, 1'b0, "R8");

        summary();
    end

endmodule